// File: doc/BRIEF.md
# NAND Page Program Command Engine

This block is the device-side command interpreter and program sequencer of a small NAND-style flash array. A host drives byte-wide bus cycles that are tagged as a command cycle, an address cycle or a data cycle. A load command, three address cycles and any number of data bytes fill a page buffer. A confirm command then starts a timed internal program of that buffer into one page of the array, and a ready/busy pin is held low while it runs. A readable status byte reports readiness and whether the last program failed.

Each page holds 256 main bytes and 8 spare bytes. A column pointer mode chooses which area the first address cycle points into, and that mode persists across operations until it is changed. Programming can only clear bits. Buffer bytes that were not loaded stay at FFh, so the matching cells keep their contents. After the write, a verify pass flags any bit that should be 0 but still reads 1. Each page has a counter of partial programs, and any program after the tenth on a page is refused and reported as failed.

The bus input never applies back-pressure: `bus_ready` is always high, and a cycle is taken on every clock edge where `bus_valid` is high. A cycle with both `bus_cle` and `bus_ale` high is ignored. A read request returns a byte one cycle later, with `rd_valid`.

Top module: `nand_prog_engine`

## Requirements
- R1: Command 80h, three address cycles (column, page row, unused) and data bytes, followed by 10h, change each stored byte of the page to (old AND loaded). Bytes that were not loaded keep their old value, and a cell bit is never set from 0 to 1.
- R2: In main mode the first address byte is the start column (0–255). In spare mode the start column is 256 plus address bits [2:0]. Each data byte advances the column by one. Bytes after column 263 are dropped, and loading does not wrap to column 0.
- R3: Command 50h selects spare mode and command 00h selects main mode. The mode persists across load and program sequences. Reset (FFh) selects main mode.
- R4: A 10h is ignored, with rb_n staying high, unless it follows an 80h, all three address cycles and at least one data byte.
- R5: After an accepted 10h, rb_n is low for exactly PROG_CYCLES (default 300) cycles, starting from the cycle after the command edge.
- R6: While busy, only 70h and FFh are accepted. All other commands, address cycles and data cycles are ignored, and this includes pointer mode changes.
- R7: After 70h every read returns the status byte: bit 6 is 1 when ready, bit 0 is 1 when the last program failed, and all other bits are 0. This holds until another valid command is written. Reads outside status mode return 00h. Ignored commands do not leave status mode.
- R8: Each page accepts ten programs. The eleventh program on the same page leaves the page unchanged, still holds rb_n low for the full program time, and sets status bit 0. Other pages count independently.
- R9: FFh aborts a running program. rb_n is high in the next cycle, the pending load is cancelled and the fail bit is cleared.
- R10: A program whose verify finds every bit at its intended value reports status bit 0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_ready | output | 1 | Always 1; the engine takes every bus cycle |
| bus_cle | input | 1 | Marks the cycle as a command |
| bus_ale | input | 1 | Marks the cycle as an address |
| bus_data | input | 8 | Command, address or data byte |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read byte valid, one cycle after rd_req |
| rd_data | output | 8 | Status byte in status mode, otherwise 00h |
| rb_n | output | 1 | Ready (1) or busy programming (0) |
| peek_row | input | 3 | Page index for the array read port |
| peek_col | input | 9 | Column for the array read port |
| peek_byte | output | 8 | Stored byte at peek_row/peek_col (combinational) |

## Verification
The hardest state to reach is the eleventh partial program on one page. Each earlier program holds the engine busy for a full program time, so the bench runs ten complete load–confirm–wait sequences on one page, each writing a different column. It then issues the refused one and checks that the page is unchanged and that the fail bit is set. Commands sent during the busy window are a second hard case. These are timed right after the confirm, and their effects are checked only once rb_n has risen again.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;
  localparam logic [7:0] CMD_PTR_MAIN  = 8'h00;
  localparam logic [7:0] CMD_PTR_SPARE = 8'h50;
  localparam logic [7:0] CMD_LOAD      = 8'h80;
  localparam logic [7:0] CMD_CONFIRM   = 8'h10;
  localparam logic [7:0] CMD_STATUS    = 8'h70;
  localparam logic [7:0] CMD_RESET     = 8'hFF;

  localparam int STAT_READY_BIT = 6;
  localparam int STAT_FAIL_BIT  = 0;

  typedef enum logic [1:0] {LD_NONE, LD_ADDR, LD_DATA} load_state_e;
endpackage

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 264,
  parameter int ROW_W      = 3,
  parameter int COL_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [7:0]       wr_byte,
  input  logic [ROW_W-1:0] ra_row,
  input  logic [COL_W-1:0] ra_col,
  output logic [7:0]       ra_byte,
  input  logic [ROW_W-1:0] rb_row,
  input  logic [COL_W-1:0] rb_col,
  output logic [7:0]       rb_byte,
  input  logic [ROW_W-1:0] rc_row,
  input  logic [COL_W-1:0] rc_col,
  output logic [7:0]       rc_byte
);
  localparam int DEPTH = PAGES * PAGE_BYTES;
  localparam int IDX_W = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];

  function automatic logic [IDX_W-1:0] flat(input logic [ROW_W-1:0] r,
                                            input logic [COL_W-1:0] c);
    flat = IDX_W'(int'(r) * PAGE_BYTES + int'(c));
  endfunction

  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       cell_at_wr;

  assign wr_idx     = flat(wr_row, wr_col);
  assign cell_at_wr = mem[wr_idx];
  assign ra_byte    = mem[flat(ra_row, ra_col)];
  assign rb_byte    = mem[flat(rb_row, rb_col)];
  assign rc_byte    = mem[flat(rc_row, rc_col)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  // R1
  no_set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_byte & ~cell_at_wr) == 8'h00));
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int PAGE_BYTES = 264,
  parameter int COL_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_col_en,
  input  logic [COL_W-1:0] set_col,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic [COL_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  input  logic [COL_W-1:0] rd2_idx,
  output logic [7:0]       rd2_byte
);
  localparam logic [COL_W-1:0] END_COL = COL_W'(PAGE_BYTES);

  logic [7:0]       bytes_q [PAGE_BYTES];
  logic [COL_W-1:0] col_q;

  assign rd_byte  = bytes_q[rd_idx];
  assign rd2_byte = bytes_q[rd2_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= 8'hFF;
      col_q <= '0;
    end else if (clr) begin
      for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= 8'hFF;
      col_q <= '0;
    end else if (set_col_en) begin
      col_q <= set_col;
    end else if (wr_en && col_q < END_COL) begin
      bytes_q[col_q] <= wr_byte;
      col_q          <= col_q + 1'b1;
    end
  end

  // R2
  col_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= END_COL);
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
  parameter int PAGES       = 8,
  parameter int PAGE_BYTES  = 264,
  parameter int ROW_W       = 3,
  parameter int COL_W       = 9,
  parameter int MAX_PARTIAL = 10,
  parameter int BUSY_CYCLES = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] start_row,
  input  logic             abort,
  output logic             busy,
  output logic             fail,
  output logic [COL_W-1:0] buf_idx,
  input  logic [7:0]       buf_byte,
  output logic [COL_W-1:0] buf_prev_idx,
  input  logic [7:0]       buf_prev_byte,
  output logic             arr_wr_en,
  output logic [ROW_W-1:0] arr_row,
  output logic [COL_W-1:0] arr_wr_col,
  output logic [7:0]       arr_wr_byte,
  input  logic [7:0]       arr_old_byte,
  output logic [COL_W-1:0] arr_vfy_col,
  input  logic [7:0]       arr_vfy_byte
);
  localparam int TMR_W = $clog2(BUSY_CYCLES + 1);
  localparam int CNT_W = $clog2(MAX_PARTIAL + 1);
  localparam logic [TMR_W-1:0] LAST_T = TMR_W'(BUSY_CYCLES - 1);
  localparam logic [TMR_W-1:0] PAGE_T = TMR_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] CAP    = CNT_W'(MAX_PARTIAL);

  logic             busy_q, skip_q, acc_fail_q, fail_q;
  logic [TMR_W-1:0] timer_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q [PAGES];
  logic             wr_phase, vfy_phase, vfy_bad;

  assign wr_phase  = busy_q && !skip_q && (timer_q < PAGE_T);
  assign vfy_phase = busy_q && !skip_q && (timer_q != '0) && (timer_q <= PAGE_T);

  assign buf_idx      = wr_phase  ? COL_W'(timer_q) : '0;
  assign buf_prev_idx = vfy_phase ? COL_W'(timer_q - 1'b1) : '0;
  assign arr_vfy_col  = buf_prev_idx;
  assign arr_wr_col   = buf_idx;
  assign arr_row      = row_q;
  assign arr_wr_en    = wr_phase && !abort;
  assign arr_wr_byte  = arr_old_byte & buf_byte;
  assign vfy_bad      = vfy_phase && ((arr_vfy_byte & ~buf_prev_byte) != 8'h00);

  assign busy = busy_q;
  assign fail = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      skip_q     <= 1'b0;
      acc_fail_q <= 1'b0;
      fail_q     <= 1'b0;
      timer_q    <= '0;
      row_q      <= '0;
      for (int p = 0; p < PAGES; p++) cnt_q[p] <= '0;
    end else if (abort) begin
      busy_q     <= 1'b0;
      acc_fail_q <= 1'b0;
      fail_q     <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      timer_q <= '0;
      row_q   <= start_row;
      if (cnt_q[start_row] >= CAP) begin
        skip_q     <= 1'b1;
        acc_fail_q <= 1'b1;
      end else begin
        skip_q           <= 1'b0;
        acc_fail_q       <= 1'b0;
        cnt_q[start_row] <= cnt_q[start_row] + 1'b1;
      end
    end else if (busy_q) begin
      if (vfy_bad) acc_fail_q <= 1'b1;
      if (timer_q == LAST_T) begin
        busy_q <= 1'b0;
        fail_q <= acc_fail_q | vfy_bad;
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !abort && timer_q != LAST_T |=> busy_q);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !abort && timer_q == LAST_T |=> !busy_q);

  // R8
  partial_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q[row_q] <= CAP);

  // R8
  skip_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && skip_q |-> !arr_wr_en);
endmodule

// File: rtl/nand_prog_engine.sv
module nand_prog_engine
  import nand_pe_pkg::*;
#(
  parameter int MAIN_BYTES      = 256,
  parameter int SPARE_BYTES     = 8,
  parameter int BLOCKS          = 2,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int PROG_CYCLES     = 300,
  parameter int MAX_PARTIAL     = 10,
  localparam int PAGE_BYTES     = MAIN_BYTES + SPARE_BYTES,
  localparam int PAGES          = BLOCKS * PAGES_PER_BLOCK,
  localparam int ROW_W          = $clog2(PAGES),
  localparam int COL_W          = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  output logic             bus_ready,
  input  logic             bus_cle,
  input  logic             bus_ale,
  input  logic [7:0]       bus_data,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rb_n,
  input  logic [ROW_W-1:0] peek_row,
  input  logic [COL_W-1:0] peek_col,
  output logic [7:0]       peek_byte
);
  localparam int SP_W        = $clog2(SPARE_BYTES);
  localparam int BUSY_CYCLES = (PROG_CYCLES > PAGE_BYTES + 1) ? PROG_CYCLES : PAGE_BYTES + 2;

  logic cmd_fire, addr_fire, data_fire, busy, seq_fail;
  logic accept, is_main, is_spare, is_load, is_status, is_reset, confirm_ok, valid_cmd;

  load_state_e      load_q;
  logic [1:0]       acnt_q;
  logic             seen_q, spare_q, stat_mode_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] start_col;

  assign bus_ready = 1'b1;
  assign cmd_fire  = bus_valid &&  bus_cle && !bus_ale;
  assign addr_fire = bus_valid && !bus_cle &&  bus_ale;
  assign data_fire = bus_valid && !bus_cle && !bus_ale;

  assign accept     = cmd_fire && (!busy || bus_data == CMD_STATUS || bus_data == CMD_RESET);
  assign is_main    = accept && bus_data == CMD_PTR_MAIN;
  assign is_spare   = accept && bus_data == CMD_PTR_SPARE;
  assign is_load    = accept && bus_data == CMD_LOAD;
  assign is_status  = accept && bus_data == CMD_STATUS;
  assign is_reset   = accept && bus_data == CMD_RESET;
  assign confirm_ok = accept && bus_data == CMD_CONFIRM && load_q == LD_DATA && seen_q;
  assign valid_cmd  = is_main || is_spare || is_load || is_status || is_reset || confirm_ok;

  assign start_col = spare_q ? COL_W'(MAIN_BYTES) + COL_W'(bus_data[SP_W-1:0])
                             : COL_W'(bus_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q      <= LD_NONE;
      acnt_q      <= '0;
      seen_q      <= 1'b0;
      spare_q     <= 1'b0;
      stat_mode_q <= 1'b0;
      row_q       <= '0;
    end else if (is_reset) begin
      load_q      <= LD_NONE;
      spare_q     <= 1'b0;
      stat_mode_q <= 1'b0;
    end else begin
      if (is_spare) spare_q <= 1'b1;
      if (is_main)  spare_q <= 1'b0;
      if (is_status)      stat_mode_q <= 1'b1;
      else if (valid_cmd) stat_mode_q <= 1'b0;
      if (is_load) begin
        load_q <= LD_ADDR;
        acnt_q <= '0;
        seen_q <= 1'b0;
      end else if (is_main || is_spare || confirm_ok) begin
        load_q <= LD_NONE;
      end else if (addr_fire && load_q == LD_ADDR && !busy) begin
        acnt_q <= acnt_q + 1'b1;
        if (acnt_q == 2'd1) row_q  <= bus_data[ROW_W-1:0];
        if (acnt_q == 2'd2) load_q <= LD_DATA;
      end else if (data_fire && load_q == LD_DATA && !busy) begin
        seen_q <= 1'b1;
      end
    end
  end

  logic [7:0] status_byte;
  always_comb begin
    status_byte                 = 8'h00;
    status_byte[STAT_READY_BIT] = !busy;
    status_byte[STAT_FAIL_BIT]  = seq_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= stat_mode_q ? status_byte : 8'h00;
    end
  end

  assign rb_n = !busy;

  logic [COL_W-1:0] b_idx, b_prev_idx, vfy_col, wr_col;
  logic [7:0]       b_byte, b_prev_byte, old_byte, vfy_byte, wr_byte;
  logic [ROW_W-1:0] arr_row;
  logic             arr_wr;

  nand_page_buf #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .clr(is_load),
    .set_col_en(addr_fire && load_q == LD_ADDR && acnt_q == 2'd0 && !busy),
    .set_col(start_col),
    .wr_en(data_fire && load_q == LD_DATA && !busy),
    .wr_byte(bus_data),
    .rd_idx(b_idx), .rd_byte(b_byte),
    .rd2_idx(b_prev_idx), .rd2_byte(b_prev_byte)
  );

  nand_prog_seq #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .COL_W(COL_W),
    .MAX_PARTIAL(MAX_PARTIAL), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(confirm_ok), .start_row(row_q), .abort(is_reset),
    .busy(busy), .fail(seq_fail),
    .buf_idx(b_idx), .buf_byte(b_byte),
    .buf_prev_idx(b_prev_idx), .buf_prev_byte(b_prev_byte),
    .arr_wr_en(arr_wr), .arr_row(arr_row), .arr_wr_col(wr_col), .arr_wr_byte(wr_byte),
    .arr_old_byte(old_byte), .arr_vfy_col(vfy_col), .arr_vfy_byte(vfy_byte)
  );

  nand_cell_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .COL_W(COL_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(arr_wr), .wr_row(arr_row), .wr_col(wr_col), .wr_byte(wr_byte),
    .ra_row(arr_row), .ra_col(wr_col), .ra_byte(old_byte),
    .rb_row(arr_row), .rb_col(vfy_col), .rb_byte(vfy_byte),
    .rc_row(peek_row), .rc_col(peek_col), .rc_byte(peek_byte)
  );

  // R6
  ptr_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !is_reset |=> $stable(spare_q));

  // R7
  status_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && stat_mode_q |=> rd_valid && rd_data[STAT_READY_BIT] == $past(rb_n));

  // R9
  reset_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_reset |=> rb_n && !spare_q);

  // R4
  lone_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && bus_data == CMD_CONFIRM && load_q != LD_DATA && rb_n |=> rb_n);
endmodule

// File: tb/tb_nand_prog_engine.sv
module tb_nand_prog_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_T     = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_cle = 1'b0, bus_ale = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic       bus_ready, rd_req = 1'b0, rd_valid, rb_n;
  logic [7:0] rd_data, peek_byte;
  logic [2:0] peek_row = '0;
  logic [8:0] peek_col = '0;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_prog_engine #(.PROG_CYCLES(PROG_T)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_data(bus_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rb_n(rb_n),
    .peek_row(peek_row), .peek_col(peek_col), .peek_byte(peek_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_cle = c; bus_ale = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_cle = 1'b0; bus_ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);  cyc(1'b1, 1'b0, c); endtask
  task automatic adr(input logic [7:0] a);  cyc(1'b0, 1'b1, a); endtask
  task automatic dat(input logic [7:0] d);  cyc(1'b0, 1'b0, d); endtask

  task automatic load(input logic [7:0] row, input logic [7:0] col);
    cmd(8'h80); adr(col); adr(row); adr(8'h00);
  endtask

  task automatic wait_ready();
    while (rb_n == 1'b0) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; v = rd_data;
  endtask

  task automatic peek(input int row, input int col, output logic [7:0] v);
    @(negedge clk); peek_row = 3'(row); peek_col = 9'(col);
    #1 v = peek_byte;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R5 reset rb_n", rb_n, 1);
    chk("R5 bus_ready", bus_ready, 1);
    rd(v); chk("R7 read outside status", v, 8'h00);
    cmd(8'h70); rd(v); chk("R7 status idle", v, 8'h40);
    peek(0, 0, v); chk("R1 erased cell", v, 8'hFF);
  endtask

  task automatic t_basic();
    logic [7:0] v; int n;
    load(1, 4); dat(8'hA5); dat(8'h3C); cmd(8'h10);
    n = 0;
    while (rb_n == 1'b0) begin n++; @(negedge clk); end
    chk("R5 busy length", n, PROG_T);
    peek(1, 4, v); chk("R1 byte4", v, 8'hA5);
    peek(1, 5, v); chk("R1 byte5", v, 8'h3C);
    peek(1, 6, v); chk("R1 unloaded after", v, 8'hFF);
    peek(1, 3, v); chk("R1 unloaded before", v, 8'hFF);
    cmd(8'h70); rd(v); chk("R10 pass status", v, 8'h40);
    load(1, 4); dat(8'h0F); dat(8'hFF); cmd(8'h10); wait_ready();
    peek(1, 4, v); chk("R1 and-only byte4", v, 8'h05);
    peek(1, 5, v); chk("R1 no 0->1 byte5", v, 8'h3C);
  endtask

  task automatic t_spare();
    logic [7:0] v;
    cmd(8'h50);
    load(2, 8'h02); dat(8'h11); dat(8'h22); cmd(8'h10); wait_ready();
    peek(2, 258, v); chk("R2 spare col 258", v, 8'h11);
    peek(2, 259, v); chk("R2 spare col 259", v, 8'h22);
    peek(2, 2, v);   chk("R2 main col2 untouched", v, 8'hFF);
    load(2, 8'h07); dat(8'h77); dat(8'h88); cmd(8'h10); wait_ready();
    peek(2, 263, v); chk("R3 spare persists col263", v, 8'h77);
    peek(2, 0, v);   chk("R2 no wrap to col0", v, 8'hFF);
    cmd(8'h00);
    load(2, 8'h02); dat(8'h33); cmd(8'h10); wait_ready();
    peek(2, 2, v);   chk("R3 main after 00h", v, 8'h33);
  endtask

  task automatic t_lone_confirm();
    logic [7:0] v;
    cmd(8'h10);
    chk("R4 lone confirm", rb_n, 1);
    load(3, 8'h00); cmd(8'h10);
    chk("R4 confirm without data", rb_n, 1);
    cmd(8'h00);
    peek(3, 0, v); chk("R4 page unchanged", v, 8'hFF);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    load(3, 8'h00); dat(8'h00); cmd(8'h10);
    cmd(8'h70); rd(v); chk("R7 status busy", v, 8'h00);
    cmd(8'h50); load(3, 8'h08); dat(8'h00); cmd(8'h10);
    wait_ready();
    rd(v); chk("R7 status persists", v, 8'h40);
    peek(3, 8, v); chk("R6 busy data ignored", v, 8'hFF);
    load(3, 8'h01); dat(8'h5A); cmd(8'h10); wait_ready();
    peek(3, 1, v); chk("R6 pointer still main", v, 8'h5A);
    peek(3, 0, v); chk("R1 first program", v, 8'h00);
    rd(v); chk("R7 status left after other cmd", v, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    cmd(8'h50);
    load(4, 8'h00); dat(8'h12); cmd(8'h10);
    repeat (5) @(negedge clk);
    cmd(8'hFF);
    chk("R9 ready after abort", rb_n, 1);
    cmd(8'h70); rd(v); chk("R9 status after abort", v, 8'h40);
    load(5, 8'h09); dat(8'h99); cmd(8'h10); wait_ready();
    peek(5, 9, v); chk("R3 reset returns main", v, 8'h99);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    for (int i = 0; i < 10; i++) begin
      load(6, 8'(i)); dat(8'(8'hF0 ^ i)); cmd(8'h10); wait_ready();
    end
    cmd(8'h70); rd(v); chk("R8 tenth passes", v, 8'h40);
    peek(6, 9, v); chk("R8 tenth stored", v, 8'hF9);
    load(6, 8'd20); dat(8'h00); cmd(8'h10);
    chk("R8 eleventh still busy", rb_n, 0);
    wait_ready();
    cmd(8'h70); rd(v); chk("R8 eleventh fails", v, 8'h41);
    peek(6, 20, v); chk("R8 page unchanged", v, 8'hFF);
    load(7, 8'h00); dat(8'h42); cmd(8'h10); wait_ready();
    cmd(8'h70); rd(v); chk("R8 other page passes", v, 8'h40);
    peek(7, 0, v); chk("R8 other page stored", v, 8'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_spare();
    t_lone_confirm();
    t_busy_ignore();
    t_abort();
    t_partial();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule